// File: doc/BRIEF.md
# Audio Stream Control State Machine

This block keeps the operating state of one direction of an audio serial port, either transmit or receive. Configuration, control commands and buffer-handoff requests come in from software-facing logic. Status comes back from the serializer datapath: a pulse when the block being shifted finishes, a level that says whether the block queue is empty, and a pulse for a transmit underrun or a receive overrun.

The block reports its state as a code. It enables the serializer while data moves and pulses a flush strobe when a queue must be discarded. It answers every configuration or command that the current state does not allow with a one-cycle error pulse, and the state does not change.

Three commands end a run. A halt command completes at the end of the current block. A flush-out command completes once the transmit queue is empty, and behaves like halt on a receive stream. An abort command completes at once. The only way out of the fault state is a dedicated recover command, or an abort.

Top module: `audio_stream_ctl`

## Requirements
- R1: After reset, state_o is UNCFG (code 0), and ser_en_o, flush_o and cmd_err_o are low.
- R2: A configuration (cfg_valid_i) is accepted only in UNCFG or READY. A nonzero cfg_rate_i moves the state to READY (code 1) and a zero rate moves it to UNCFG. In any other state the configuration is refused.
- R3: START (cmd_i code 0) is legal only in READY and moves the state to RUN (code 2). On a transmit stream (IS_TX=1) it also needs q_empty_i low.
- R4: HALT (code 1) is legal only in RUN. It moves the state to HALTING (code 3) and then to READY on the first blk_end_i pulse. A later START resumes in RUN.
- R5: FLUSHOUT (code 2) is legal only in RUN and moves the state to HALTING. On a transmit stream it returns to READY only on a blk_end_i pulse with q_empty_i high. On a receive stream it returns on the first blk_end_i pulse, like HALT.
- R6: ABORT (code 3) is legal in every state except UNCFG. In the next cycle the state is READY and flush_o is high for exactly one cycle. In UNCFG it is refused and no flush is issued.
- R7: RECOVER (code 4) is legal only in FAULT (code 4) and moves the state to READY.
- R8: xrun_i in RUN or HALTING moves the state to FAULT. This overrides a command in the same cycle, and that command is refused. In other states xrun_i has no effect.
- R9: A refused command or configuration leaves the state unchanged unless R8 applies, and raises cmd_err_o for exactly the following cycle. Command codes 5 to 7 are always refused. A command in the same cycle as a configuration is refused.
- R10: ser_en_o is high exactly while the state is RUN or HALTING.
- R11: On a transmit stream, blk_req_i gets blk_ack_o in the same cycle when the state is READY or RUN, and blk_nak_o otherwise.
- R12: On a receive stream, blk_req_i gets blk_ack_o in the same cycle when the state is not UNCFG and q_empty_i is low, and blk_nak_o otherwise. Buffered data can therefore still be read out in FAULT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_valid_i | input | 1 | Configuration request |
| cfg_rate_i | input | RATE_W | Frame rate carried by the configuration; zero unconfigures |
| cmd_valid_i | input | 1 | Command request |
| cmd_i | input | 3 | Command code: 0 start, 1 halt, 2 flush-out, 3 abort, 4 recover |
| blk_end_i | input | 1 | Current block finished in the serializer |
| q_empty_i | input | 1 | Block queue is empty |
| xrun_i | input | 1 | Underrun (transmit) or overrun (receive) |
| blk_req_i | input | 1 | Request to hand over a block (write for transmit, read for receive) |
| state_o | output | 3 | State code |
| ser_en_o | output | 1 | Serializer enable |
| flush_o | output | 1 | One-cycle queue flush strobe |
| cmd_err_o | output | 1 | One-cycle refusal of a command or configuration |
| blk_ack_o | output | 1 | Block handoff accepted |
| blk_nak_o | output | 1 | Block handoff refused |

## Verification
The state register drives every output, so a wrong state shows up on state_o and ser_en_o at the first sample after the offending clock edge. A legality error shows up one cycle later as a cmd_err_o pulse that is missing or unexpected. The subtle failures are in completion conditions: a flush-out that returns early because it ignores q_empty_i, or an underrun that loses to a command in the same cycle. Both are visible only as state_o in the cycle right after the blk_end_i or xrun_i pulse. Faults in the handoff gate appear combinationally on blk_ack_o and blk_nak_o in the same cycle as the request.

// File: rtl/astr_pkg.sv
package astr_pkg;
  typedef enum logic [2:0] {
    ST_UNCFG   = 3'd0,
    ST_READY   = 3'd1,
    ST_RUN     = 3'd2,
    ST_HALTING = 3'd3,
    ST_FAULT   = 3'd4
  } st_e;

  typedef enum logic [2:0] {
    OP_START    = 3'd0,
    OP_HALT     = 3'd1,
    OP_FLUSHOUT = 3'd2,
    OP_ABORT    = 3'd3,
    OP_RECOVER  = 3'd4
  } op_e;
endpackage

// File: rtl/astr_legal.sv
module astr_legal
  import astr_pkg::*;
#(
  parameter bit IS_TX = 1'b1
) (
  input  st_e        st_i,
  input  logic       cfg_v_i,
  input  logic       cmd_v_i,
  input  logic [2:0] cmd_i,
  input  logic       xrun_i,
  input  logic       q_empty_i,
  output logic       cfg_take_o,
  output logic       cmd_take_o,
  output logic       xrun_take_o,
  output logic       reject_o
);
  logic cfg_ok, cmd_ok, active;

  assign active = (st_i == ST_RUN) || (st_i == ST_HALTING);
  assign cfg_ok = (st_i == ST_UNCFG) || (st_i == ST_READY);

  always_comb begin
    cmd_ok = 1'b0;
    unique case (cmd_i)
      OP_START:    cmd_ok = (st_i == ST_READY) && (!IS_TX || !q_empty_i);
      OP_HALT,
      OP_FLUSHOUT: cmd_ok = (st_i == ST_RUN);
      OP_ABORT:    cmd_ok = (st_i != ST_UNCFG);
      OP_RECOVER:  cmd_ok = (st_i == ST_FAULT);
      default:     cmd_ok = 1'b0;
    endcase
  end

  assign xrun_take_o = xrun_i && active;
  assign cfg_take_o  = cfg_v_i && cfg_ok && !xrun_take_o;
  assign cmd_take_o  = cmd_v_i && cmd_ok && !cfg_v_i && !xrun_take_o;
  assign reject_o    = (cfg_v_i && !cfg_take_o) || (cmd_v_i && !cmd_take_o);
endmodule

// File: rtl/astr_next.sv
module astr_next
  import astr_pkg::*;
#(
  parameter bit IS_TX = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cfg_take_i,
  input  logic       rate_zero_i,
  input  logic       cmd_take_i,
  input  logic [2:0] cmd_i,
  input  logic       xrun_take_i,
  input  logic       blk_end_i,
  input  logic       q_empty_i,
  output st_e        st_o,
  output logic       flush_o
);
  st_e  st_q, st_d;
  logic wait_empty_q, wait_empty_d;

  always_comb begin
    st_d         = st_q;
    wait_empty_d = wait_empty_q;
    if (xrun_take_i) begin
      st_d = ST_FAULT;
    end else if (cfg_take_i) begin
      st_d = rate_zero_i ? ST_UNCFG : ST_READY;
    end else if (cmd_take_i) begin
      unique case (cmd_i)
        OP_START:    st_d = ST_RUN;
        OP_HALT:     begin st_d = ST_HALTING; wait_empty_d = 1'b0; end
        OP_FLUSHOUT: begin st_d = ST_HALTING; wait_empty_d = IS_TX; end
        default:     st_d = ST_READY;  // abort, recover
      endcase
    end else if (st_q == ST_HALTING && blk_end_i && (!wait_empty_q || q_empty_i)) begin
      st_d = ST_READY;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_UNCFG;
      wait_empty_q <= 1'b0;
      flush_o      <= 1'b0;
    end else begin
      st_q         <= st_d;
      wait_empty_q <= wait_empty_d;
      flush_o      <= cmd_take_i && (cmd_i == OP_ABORT);
    end
  end

  assign st_o = st_q;

  // halting only ever completes to READY or is overridden by fault/abort
  a_r5_halt_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HALTING && !xrun_take_i && !cmd_take_i && !blk_end_i) |=> st_q == ST_HALTING);
endmodule

// File: rtl/astr_gate.sv
module astr_gate
  import astr_pkg::*;
#(
  parameter bit IS_TX = 1'b1
) (
  input  st_e  st_i,
  input  logic req_i,
  input  logic q_empty_i,
  output logic ack_o,
  output logic nak_o
);
  logic allow;

  generate
    if (IS_TX) begin : g_tx
      assign allow = (st_i == ST_READY) || (st_i == ST_RUN);
    end else begin : g_rx
      assign allow = (st_i != ST_UNCFG) && !q_empty_i;
    end
  endgenerate

  assign ack_o = req_i && allow;
  assign nak_o = req_i && !allow;
endmodule

// File: rtl/audio_stream_ctl.sv
module audio_stream_ctl
  import astr_pkg::*;
#(
  parameter bit          IS_TX  = 1'b1,
  parameter int unsigned RATE_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_valid_i,
  input  logic [RATE_W-1:0] cfg_rate_i,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_i,
  input  logic              blk_end_i,
  input  logic              q_empty_i,
  input  logic              xrun_i,
  input  logic              blk_req_i,
  output logic [2:0]        state_o,
  output logic              ser_en_o,
  output logic              flush_o,
  output logic              cmd_err_o,
  output logic              blk_ack_o,
  output logic              blk_nak_o
);
  st_e  st;
  logic cfg_take, cmd_take, xrun_take, reject;

  astr_legal #(.IS_TX(IS_TX)) u_legal (
    .st_i(st), .cfg_v_i(cfg_valid_i), .cmd_v_i(cmd_valid_i), .cmd_i(cmd_i),
    .xrun_i(xrun_i), .q_empty_i(q_empty_i), .cfg_take_o(cfg_take),
    .cmd_take_o(cmd_take), .xrun_take_o(xrun_take), .reject_o(reject)
  );

  astr_next #(.IS_TX(IS_TX)) u_next (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_take_i(cfg_take),
    .rate_zero_i(cfg_rate_i == '0), .cmd_take_i(cmd_take), .cmd_i(cmd_i),
    .xrun_take_i(xrun_take), .blk_end_i(blk_end_i), .q_empty_i(q_empty_i),
    .st_o(st), .flush_o(flush_o)
  );

  astr_gate #(.IS_TX(IS_TX)) u_gate (
    .st_i(st), .req_i(blk_req_i), .q_empty_i(q_empty_i),
    .ack_o(blk_ack_o), .nak_o(blk_nak_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cmd_err_o <= 1'b0;
    else         cmd_err_o <= reject;
  end

  assign state_o  = st;
  assign ser_en_o = (st == ST_RUN) || (st == ST_HALTING);

  a_r6_flush_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> (state_o == 3'd1) && $past(cmd_valid_i && cmd_i == 3'd3));

  a_r9_refuse_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_err_o && !$past(xrun_i) && !$past(cfg_valid_i)) |-> state_o == $past(state_o));

  a_r3_start_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_o) == 3'd1 && state_o == 3'd2) |-> $past(cmd_valid_i && cmd_i == 3'd0));

  a_r8_fault_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd4 && $past(state_o) != 3'd4) |-> $past(xrun_i));

  a_r7_fault_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd4 && !cmd_valid_i) |=> state_o == 3'd4);

  generate
    if (IS_TX) begin : g_tx_chk
      a_r3_tx_needs_blk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(state_o) == 3'd1 && state_o == 3'd2) |-> !$past(q_empty_i));
    end
  endgenerate
endmodule

// File: tb/sim_audio_stream_ctl.sv
`timescale 1ns/1ps
module sim_audio_stream_ctl;
  localparam int RW = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          cfg_v   [2];
  logic [RW-1:0] cfg_rate[2];
  logic          cmd_v   [2];
  logic [2:0]    cmd     [2];
  logic          blk_end [2];
  logic          q_empty [2];
  logic          xrun    [2];
  logic          req     [2];
  logic [2:0]    st      [2];
  logic          ser_en  [2];
  logic          flush   [2];
  logic          err     [2];
  logic          ack     [2];
  logic          nak     [2];

  audio_stream_ctl #(.IS_TX(1'b1), .RATE_W(RW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_valid_i(cfg_v[0]), .cfg_rate_i(cfg_rate[0]),
    .cmd_valid_i(cmd_v[0]), .cmd_i(cmd[0]), .blk_end_i(blk_end[0]),
    .q_empty_i(q_empty[0]), .xrun_i(xrun[0]), .blk_req_i(req[0]),
    .state_o(st[0]), .ser_en_o(ser_en[0]), .flush_o(flush[0]), .cmd_err_o(err[0]),
    .blk_ack_o(ack[0]), .blk_nak_o(nak[0]));

  audio_stream_ctl #(.IS_TX(1'b0), .RATE_W(RW)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_valid_i(cfg_v[1]), .cfg_rate_i(cfg_rate[1]),
    .cmd_valid_i(cmd_v[1]), .cmd_i(cmd[1]), .blk_end_i(blk_end[1]),
    .q_empty_i(q_empty[1]), .xrun_i(xrun[1]), .blk_req_i(req[1]),
    .state_o(st[1]), .ser_en_o(ser_en[1]), .flush_o(flush[1]), .cmd_err_o(err[1]),
    .blk_ack_o(ack[1]), .blk_nak_o(nak[1]));

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic apply(input int d, input bit cv, input int rate, input bit mv,
                       input int c, input bit be, input bit xr);
    @(negedge clk);
    cfg_v[d] = cv; cfg_rate[d] = rate[RW-1:0]; cmd_v[d] = mv; cmd[d] = c[2:0];
    blk_end[d] = be; xrun[d] = xr;
    @(negedge clk);
    cfg_v[d] = 1'b0; cmd_v[d] = 1'b0; blk_end[d] = 1'b0; xrun[d] = 1'b0;
  endtask

  task automatic op(input int d, input int c);
    apply(d, 1'b0, 0, 1'b1, c, 1'b0, 1'b0);
  endtask

  task automatic conf(input int d, input int rate);
    apply(d, 1'b1, rate, 1'b0, 0, 1'b0, 1'b0);
  endtask

  task automatic blk(input int d, input bit exp_ack, input string tag);
    req[d] = 1'b1;
    #1;
    chk(tag, ack[d], exp_ack);
    chk(tag, nak[d], !exp_ack);
    req[d] = 1'b0;
  endtask

  task automatic t_reset;
    for (int d = 0; d < 2; d++) begin
      chk("R1 state", st[d], 0);
      chk("R1 ser_en", ser_en[d], 0);
      chk("R1 flush", flush[d], 0);
      chk("R1 err", err[d], 0);
    end
  endtask

  task automatic t_config;
    op(0, 0);
    chk("R9 start in uncfg err", err[0], 1);
    chk("R3 start in uncfg state", st[0], 0);
    apply(0, 0, 0, 0, 0, 0, 0);
    chk("R9 err one cycle", err[0], 0);
    blk(0, 1'b0, "R11 write in uncfg");
    conf(0, 0);
    chk("R2 zero rate state", st[0], 0);
    chk("R2 zero rate no err", err[0], 0);
    conf(0, 48000);
    chk("R2 configured", st[0], 1);
    blk(0, 1'b1, "R11 write in ready");
    op(0, 6);
    chk("R9 bad code err", err[0], 1);
    chk("R9 bad code state", st[0], 1);
    q_empty[0] = 1'b0;
    apply(0, 1, 44100, 1, 0, 0, 0);
    chk("R9 cmd with cfg err", err[0], 1);
    chk("R9 cmd with cfg state", st[0], 1);
  endtask

  task automatic t_start;
    q_empty[0] = 1'b1;
    op(0, 0);
    chk("R3 tx start empty err", err[0], 1);
    chk("R3 tx start empty state", st[0], 1);
    q_empty[0] = 1'b0;
    op(0, 0);
    chk("R3 start state", st[0], 2);
    chk("R3 start no err", err[0], 0);
    chk("R10 ser_en run", ser_en[0], 1);
    conf(0, 8000);
    chk("R2 cfg in run err", err[0], 1);
    chk("R2 cfg in run state", st[0], 2);
    blk(0, 1'b1, "R11 write in run");
  endtask

  task automatic t_halt;
    op(0, 1);
    chk("R4 halting", st[0], 3);
    chk("R10 ser_en halting", ser_en[0], 1);
    apply(0, 0, 0, 0, 0, 0, 0);
    chk("R4 waits for block end", st[0], 3);
    blk(0, 1'b0, "R11 write in halting");
    apply(0, 0, 0, 0, 0, 1, 0);
    chk("R4 ready at block end", st[0], 1);
    chk("R10 ser_en ready", ser_en[0], 0);
    op(0, 0);
    chk("R4 resume", st[0], 2);
  endtask

  task automatic t_flushout;
    op(0, 2);
    chk("R5 tx flushout halting", st[0], 3);
    apply(0, 0, 0, 0, 0, 1, 0);
    chk("R5 tx waits for empty", st[0], 3);
    q_empty[0] = 1'b1;
    apply(0, 0, 0, 0, 0, 1, 0);
    chk("R5 tx ready when empty", st[0], 1);
  endtask

  task automatic t_fault;
    q_empty[0] = 1'b0;
    op(0, 0);
    chk("R3 restart", st[0], 2);
    apply(0, 0, 0, 1, 3, 0, 1);
    chk("R8 fault", st[0], 4);
    chk("R8 cmd refused", err[0], 1);
    chk("R8 no flush", flush[0], 0);
    op(0, 0);
    chk("R9 start in fault err", err[0], 1);
    chk("R9 start in fault state", st[0], 4);
    blk(0, 1'b0, "R11 write in fault");
    op(0, 4);
    chk("R7 recover", st[0], 1);
    chk("R7 recover no err", err[0], 0);
    op(0, 4);
    chk("R7 recover in ready err", err[0], 1);
    apply(0, 0, 0, 0, 0, 0, 1);
    chk("R8 xrun in ready ignored", st[0], 1);
  endtask

  task automatic t_abort;
    op(0, 0);
    op(0, 3);
    chk("R6 abort state", st[0], 1);
    chk("R6 flush", flush[0], 1);
    chk("R10 ser_en after abort", ser_en[0], 0);
    apply(0, 0, 0, 0, 0, 0, 0);
    chk("R6 flush one cycle", flush[0], 0);
    op(0, 3);
    chk("R6 abort in ready flush", flush[0], 1);
    chk("R6 abort in ready state", st[0], 1);
    op(0, 0);
    op(0, 1);
    op(0, 3);
    chk("R6 abort from halting", st[0], 1);
    chk("R6 abort from halting flush", flush[0], 1);
    conf(0, 0);
    chk("R2 unconfigure", st[0], 0);
    op(0, 3);
    chk("R6 abort in uncfg err", err[0], 1);
    chk("R6 abort in uncfg no flush", flush[0], 0);
    chk("R6 abort in uncfg state", st[0], 0);
  endtask

  task automatic t_rx;
    conf(1, 16000);
    chk("R2 rx configured", st[1], 1);
    q_empty[1] = 1'b1;
    op(1, 0);
    chk("R3 rx start without blocks", st[1], 2);
    blk(1, 1'b0, "R12 rx read empty");
    q_empty[1] = 1'b0;
    blk(1, 1'b1, "R12 rx read data");
    op(1, 2);
    chk("R5 rx flushout halting", st[1], 3);
    apply(1, 0, 0, 0, 0, 1, 0);
    chk("R5 rx flushout like halt", st[1], 1);
    op(1, 0);
    apply(1, 0, 0, 0, 0, 0, 1);
    chk("R8 rx overrun", st[1], 4);
    blk(1, 1'b1, "R12 rx read in fault");
    q_empty[1] = 1'b1;
    blk(1, 1'b0, "R12 rx read fault empty");
    op(1, 4);
    conf(1, 0);
    chk("R2 rx unconfigured", st[1], 0);
    q_empty[1] = 1'b0;
    blk(1, 1'b0, "R12 rx read in uncfg");
  endtask

  initial begin
    for (int d = 0; d < 2; d++) begin
      cfg_v[d] = 0; cfg_rate[d] = '0; cmd_v[d] = 0; cmd[d] = '0;
      blk_end[d] = 0; q_empty[d] = 1; xrun[d] = 0; req[d] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_config();
    t_start();
    t_halt();
    t_flushout();
    t_fault();
    t_abort();
    t_rx();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule